// File: doc/BRIEF.md
# Load-Accumulator Instruction Sequencer

This block is a minimal processor control path that carries out one instruction: load the accumulator from memory. It has the usual registers: a program counter, an address register, an instruction register, a data register, an accumulator and a step counter. A decoder turns the step counter into one-hot timing strobes. A second decoder turns the three opcode bits of the instruction word into one-hot operation lines. Every register update is gated by the AND of its timing strobe with the operation line and the indirect flag it depends on. A register holds its value in every other cycle.

Instruction words are 16 bits. Bit 15 is the indirect flag, bits 14:12 are the opcode (value 3'b010 selects the load) and bits 11:0 are the operand address. A direct load takes four cycles. An indirect load takes six: it reads a pointer word, keeps the pointer's low 12 bits as the effective address, and then loads. Any other opcode takes four cycles and changes nothing except the program counter. The word memory has a combinational read port addressed by the address register. It is filled through a load port, typically while the block is held in reset. The accumulator, program counter and step counter are brought out so that they can be observed.

Top module: `lda_sequencer`

## Requirements
- R1: While rst_n is low, ac_o, pc_o and sc_o read zero, asynchronously. After rst_n rises, two clock edges pass before the first instruction step is taken, and the next instruction starts at address 0.
- R2: The step counter counts 0,1,2,... one step per clock. Exactly one timing strobe is active in every cycle. In step 0 the address register takes the program counter.
- R3: In step 1 the program counter increments by one, exactly once per instruction. It does not change in any other step.
- R4: A direct load (bit 15 = 0, bits 14:12 = 3'b010) sets ac_o to the memory word at the operand address four clock edges after the instruction starts, and sc_o returns to 0 at that same edge.
- R5: An indirect load (bit 15 = 1, bits 14:12 = 3'b010) reads a pointer from the operand address. It then sets ac_o to the word at the pointer's bits 11:0, six edges after the instruction starts, with sc_o back at 0.
- R6: Any instruction whose bits 14:12 differ from 3'b010 completes in four edges, whatever its bit 15 is. It leaves ac_o unchanged.
- R7: ac_o changes only in the final step of a load. During the earlier steps it holds its old value. After three edges of a direct load sc_o reads 3, and after five edges of an indirect load sc_o reads 5.
- R8: Memory is indexed by the low MEM_AW bits of the address register, so address bits above MEM_AW and pointer bits 15:12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_we | input | 1 | Memory load strobe |
| mem_waddr | input | MEM_AW | Memory load address |
| mem_wdata | input | 16 | Memory load word |
| ac_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| sc_o | output | SC_W | Step counter |

## Verification
The bench builds the block with its defaults, MEM_AW = 8 and SC_W = 3: a 256-word memory and eight timing strobes, two of which are never reached. The small memory brings address aliasing within reach. A 12-bit operand such as 0x1C4 lands on word 0xC4, and a pointer's upper bits are dropped twice over: once as bits 15:12 and once above bit 7. A walk through mixed direct, indirect and non-load words then confirms the cycle count and the accumulator after every instruction.

// File: rtl/lda_pkg.sv
package lda_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = 3;
  localparam logic [OP_W-1:0] OP_LOAD = 3'b010;

  typedef struct packed {
    logic              ind;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
  } instr_t;
endpackage

// File: rtl/lda_decoder.sv
module lda_decoder #(
  parameter int IN_W = 3,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel,
  output logic [OUT_N-1:0] hot
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign hot[g] = (sel == IN_W'(g));
  end
endmodule

// File: rtl/lda_step_counter.sv
module lda_step_counter #(
  parameter int SC_W = 3,
  localparam int T_N = 1 << SC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [SC_W-1:0] sc,
  output logic [T_N-1:0]  t
);
  logic [SC_W-1:0] sc_q, sc_d;

  always_comb begin
    if (clr) sc_d = '0;
    else     sc_d = sc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= sc_d;
  end

  lda_decoder #(.IN_W(SC_W)) u_tdec (.sel(sc_q), .hot(t));

  assign sc = sc_q;

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(t));
  p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> sc_q == $past(sc_q) + 1'b1);
endmodule

// File: rtl/lda_memory.sv
module lda_memory #(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lda_sequencer.sv
module lda_sequencer
  import lda_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int SC_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_we,
  input  logic [MEM_AW-1:0]   mem_waddr,
  input  logic [WORD_W-1:0]   mem_wdata,
  output logic [WORD_W-1:0]   ac_o,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [SC_W-1:0]     sc_o
);
  localparam int T_N = 1 << SC_W;
  localparam int D_N = 1 << OP_W;
  localparam logic [D_N-1:0] LOAD_LINE = D_N'(1) << OP_LOAD;
  localparam int LAST_STEP = 5;

  // reset release synchronizer
  logic rs1_q, rs2_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  logic [ADDR_W-1:0] pc_q, pc_d, ar_q, ar_d;
  instr_t            ir_q;
  logic [WORD_W-1:0] dr_q, ac_q, mem_rd;
  logic              ind_q;
  logic [SC_W-1:0]   sc;
  logic [T_N-1:0]    t;
  logic [D_N-1:0]    d;

  logic load_op, dir_exec, ind_fetch, ind_addr, ind_exec;
  logic pc_en, ar_en, ir_en, dr_en, ind_en, ac_en, sc_clr;

  lda_memory #(.AW(MEM_AW), .DW(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ar_q[MEM_AW-1:0]), .rdata(mem_rd)
  );

  lda_step_counter #(.SC_W(SC_W)) u_sc (
    .clk(clk), .rst_n(rst_sync_n), .clr(sc_clr), .sc(sc), .t(t)
  );

  lda_decoder #(.IN_W(OP_W)) u_opdec (.sel(ir_q.op), .hot(d));

  // control: strobe AND operation line AND flag
  always_comb begin
    load_op   = |(d & LOAD_LINE);
    dir_exec  = t[3] & load_op & ~ind_q;
    ind_fetch = t[3] & load_op &  ind_q;
    ind_addr  = t[4] & load_op &  ind_q;
    ind_exec  = t[5] & load_op &  ind_q;

    pc_en  = t[1];
    ir_en  = t[1];
    dr_en  = t[1] | ind_fetch;
    ind_en = t[2];
    ar_en  = t[0] | t[2] | ind_addr;
    ac_en  = dir_exec | ind_exec;
    sc_clr = ac_en | (t[3] & ~ind_fetch) | (sc > SC_W'(LAST_STEP));

    pc_d = pc_q + 1'b1;
    if (t[0])      ar_d = pc_q;
    else if (t[2]) ar_d = ir_q.addr;
    else           ar_d = dr_q[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      ind_q <= 1'b0;
      ac_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ar_en)  ar_q  <= ar_d;
      if (ir_en)  ir_q  <= mem_rd;
      if (dr_en)  dr_q  <= mem_rd;
      if (ind_en) ind_q <= ir_q.ind;
      if (ac_en)  ac_q  <= mem_rd;
    end
  end

  assign ac_o = ac_q;
  assign pc_o = pc_q;
  assign sc_o = sc;

  p_ar_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    t[0] |=> ar_q == $past(pc_q));
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sc == SC_W'(1)) |=> pc_q == $past(pc_q) + 1'b1);
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sc != SC_W'(1)) |=> $stable(pc_q));
  p_ac_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sc != SC_W'(3) && sc != SC_W'(5)) |=> $stable(ac_q));
  p_nonload_end_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sc == SC_W'(3) && ir_q.op != OP_LOAD) |=> (sc == '0 && $stable(ac_q)));
  p_sc_range_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sc <= SC_W'(LAST_STEP));
  p_ptr_capture_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ind_fetch |=> dr_q == $past(mem_rd));
endmodule

// File: tb/sim_lda_sequencer.sv
module sim_lda_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_waddr = '0;
  logic [15:0] mem_wdata = '0;
  logic [15:0] ac_o;
  logic [11:0] pc_o;
  logic [2:0]  sc_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lda_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .ac_o(ac_o), .pc_o(pc_o), .sc_o(sc_o)
  );

  // {instruction, edges, expected accumulator}
  localparam logic [35:0] VEC [8] = '{
    {16'h2040, 4'd4, 16'h1234},  // R4 direct
    {16'hA050, 4'd6, 16'hBEEF},  // R5 indirect
    {16'h7040, 4'd4, 16'hBEEF},  // R6 other opcode
    {16'hA051, 4'd6, 16'h8001},  // R5/R8 pointer upper bits dropped
    {16'hC040, 4'd4, 16'h8001},  // R6 bit 15 set, other opcode
    {16'h21C4, 4'd4, 16'h5A5A},  // R8 operand aliasing
    {16'h0040, 4'd4, 16'h5A5A},  // R6 opcode 0
    {16'h2042, 4'd4, 16'h8001}   // R4 direct
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = a; mem_wdata = v;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset ac", ac_o, 16'h0);
    chk("R1 reset pc", {4'h0, pc_o}, 16'h0);
    chk("R1 reset sc", {13'h0, sc_o}, 16'h0);
    for (int a = 0; a < 256; a++) wr(8'(a), 16'h0000);
    for (int i = 0; i < 8; i++) wr(8'(i), VEC[i][35:20]);
    wr(8'h08, 16'h2040);
    wr(8'h09, 16'hA040);
    wr(8'h40, 16'h1234);
    wr(8'h41, 16'hBEEF);
    wr(8'h42, 16'h8001);
    wr(8'h50, 16'h0041);
    wr(8'h51, 16'hF042);
    wr(8'hC4, 16'h5A5A);
    wr(8'h34, 16'h7777);

    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 sync release pc", {4'h0, pc_o}, 16'h0);
    chk("R1 sync release sc", {13'h0, sc_o}, 16'h0);

    for (int i = 0; i < 8; i++) begin
      repeat (int'(VEC[i][19:16])) @(posedge clk);
      @(negedge clk);
      chk("R4/R5/R6 ac", ac_o, VEC[i][15:0]);
      chk("R3 pc", {4'h0, pc_o}, 16'(i + 1));
      chk("R2 sc back to 0", {13'h0, sc_o}, 16'h0);
    end

    // direct load observed mid-way
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 direct step 3 sc", {13'h0, sc_o}, 16'h3);
    chk("R7 direct ac held", ac_o, 16'h8001);
    chk("R3 pc during instr", {4'h0, pc_o}, 16'h9);
    @(posedge clk); @(negedge clk);
    chk("R4 direct ac", ac_o, 16'h1234);

    // indirect load, pointer 0x1234 aliases to word 0x34
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 indirect step 5 sc", {13'h0, sc_o}, 16'h5);
    chk("R7 indirect ac held", ac_o, 16'h1234);
    @(posedge clk); @(negedge clk);
    chk("R8 indirect aliased ac", ac_o, 16'h7777);
    chk("R5 indirect sc", {13'h0, sc_o}, 16'h0);
    chk("R3 pc", {4'h0, pc_o}, 16'hA);

    // asynchronous reset in mid-instruction
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async ac", ac_o, 16'h0);
    chk("R1 async pc", {4'h0, pc_o}, 16'h0);
    chk("R1 async sc", {13'h0, sc_o}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule